// File: doc/BRIEF.md
# Dual-Image Reconfiguration Controller

This block decides which of two configuration images a device runs: a fixed factory image or an updatable application image. It keeps a 38-bit control word that holds four things: an image-type flag, the upper 24 bits of a boot start address, a watchdog enable and a 12-bit watchdog timeout. It also keeps a sticky 5-bit record of why the device last fell back to the factory image. Both registers sit behind a small register port. Reads of that port are combinational.

While the factory image is active, its logic programs the control word and sets the image-type flag. It then raises the internal reconfiguration request. The block answers with a one-cycle reconfigure pulse that carries the 32-bit application start address. From then on the control word is read-only and the user watchdog runs. The application must refresh the watchdog. Several events send the device back to the factory image:

- a watchdog expiry,
- a CRC error during the application load,
- the external error line,
- the external configuration request,
- an internal request.

Each such fallback records its cause, clears the control word and issues a reconfigure pulse with start address zero.

Top module: `recfg_ctrl_unit`

## Requirements
- R1: After power-on reset, the control word reads 0, the status reads 0 and `recfg_pulse` stays low.
- R2: The control word is laid out as follows: bit 0 is the image-type flag (1 means application), bits 24:1 are start-address bits 31:8, bit 25 is the watchdog enable and bits 37:26 are the timeout. While bit 0 is 0, a write with `reg_sel`=0 stores all 38 bits, and the same value reads back.
- R3: While control bit 0 is 1, writes to the control word are ignored.
- R4: `core_reconfig` with control bit 0 set, while the factory image is running, launches the application. `recfg_pulse` is high for exactly the one cycle after the request edge, and `recfg_addr` carries {bits 24:1, 8'h00}.
- R5: Every fallback clears the control word to 0 and raises `recfg_pulse` for one cycle with `recfg_addr` 0, in the cycle after the cause is sampled. `ext_err` sets status bit 1.
- R6: `ext_cfg_req` causes a fallback and sets status bit 3.
- R7: `core_reconfig` while the application is running causes a fallback and sets status bit 2.
- R8: `crc_err` causes a fallback and sets status bit 0 only while the application is running. In the factory image it has no effect.
- R9: The watchdog runs while control bit 0 or bit 25 is set, counting cycles with `tick_en` high. The limit is L = timeout << PRESCALE. Expiry falls on the (L+1)th counted tick after the count was last cleared, and sets status bit 4 and causes a fallback. A launch or a fallback clears the count.
- R10: `wdog_kick` clears the watchdog count. With a kick at edge K and ticks on every cycle, expiry falls at edge K+L+1.
- R11: Causes that arrive in the same cycle all set their status bits. Status bits are sticky until the next power-on reset.
- R12: A read with `reg_sel`=1 returns the status in bits 4:0 and zeros in bits 37:5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low power-on reset |
| tick_en | input | 1 | Watchdog count enable |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 1 | 0 selects the control word, 1 selects the status |
| reg_wdata | input | 38 | Write data |
| reg_rdata | output | 38 | Read data for the selected register |
| wdog_kick | input | 1 | Watchdog refresh |
| crc_err | input | 1 | CRC error seen during the application load |
| ext_err | input | 1 | External error line asserted |
| ext_cfg_req | input | 1 | External configuration request asserted |
| core_reconfig | input | 1 | Reconfiguration request from internal logic |
| recfg_pulse | output | 1 | One-cycle reconfigure strobe |
| recfg_addr | output | 32 | Start address of the image to load |

## Verification
A cause or launch request sampled at one rising edge produces `recfg_pulse`, the updated status and the cleared control word right after that edge. The bench drives inputs on the falling edge and samples on the following falling edge. Watchdog expiry is due L+1 counted ticks after the last clear. The bench steps through that window one cycle at a time and requires the pulse to be low on every step before the due edge. Register reads are combinational and are checked 1 ns after the bench sets `reg_sel` on a falling edge.

// File: rtl/recfg_pkg.sv
package recfg_pkg;
  localparam int CTRL_W  = 38;
  localparam int ADDR_W  = 32;
  localparam int START_W = 24;
  localparam int TO_W    = 12;
  localparam int STAT_W  = 5;
  localparam int ALIGN_W = ADDR_W - START_W;

  typedef struct packed {
    logic [TO_W-1:0]    wd_timeout;
    logic               wd_en;
    logic [START_W-1:0] start_hi;
    logic               app_image;
  } ctrl_t;

  typedef struct packed {
    logic wdog;
    logic cfg_req;
    logic core;
    logic ext_err;
    logic crc;
  } cause_t;

  typedef enum logic {
    SEL_CTRL = 1'b0,
    SEL_STAT = 1'b1
  } reg_sel_e;
endpackage

// File: rtl/recfg_rst_sync.sv
module recfg_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/recfg_ctrl_regs.sv
module recfg_ctrl_regs
  import recfg_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  wr_en,
  input  ctrl_t wdata,
  input  logic  fallback,
  output ctrl_t ctrl_q
);
  ctrl_t ctrl_d;
  logic  wr_ok;

  assign wr_ok = wr_en && !ctrl_q.app_image;

  always_comb begin
    ctrl_d = ctrl_q;
    if (fallback)   ctrl_d = '0;
    else if (wr_ok) ctrl_d = wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ctrl_q <= '0;
    else        ctrl_q <= ctrl_d;
  end
endmodule

// File: rtl/recfg_wdog.sv
module recfg_wdog #(
  parameter int TO_W     = 12,
  parameter int PRESCALE = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            run,
  input  logic            tick_en,
  input  logic            kick,
  input  logic            clear,
  input  logic [TO_W-1:0] timeout,
  output logic            expire
);
  localparam int CNT_W = TO_W + PRESCALE;

  logic [CNT_W-1:0] cnt_q, cnt_d, limit;
  logic             at_limit;

  assign limit    = {timeout, {PRESCALE{1'b0}}};
  assign at_limit = (cnt_q >= limit);
  assign expire   = run && tick_en && !kick && at_limit;

  always_comb begin
    cnt_d = cnt_q;
    if (clear || kick || !run)     cnt_d = '0;
    else if (tick_en && !at_limit) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/recfg_sequencer.sv
module recfg_sequencer
  import recfg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  ctrl_t             ctrl,
  input  logic              core_req,
  input  logic              crc_err,
  input  logic              ext_err,
  input  logic              cfg_req,
  input  logic              wd_expire,
  output cause_t            cause,
  output logic              fallback,
  output logic              launch,
  output logic              pulse_q,
  output logic [ADDR_W-1:0] addr_q
);
  logic              app_active_q, app_active_d;
  logic              launch_req;
  logic              pulse_d;
  logic [ADDR_W-1:0] addr_d;

  assign launch_req = core_req && ctrl.app_image && !app_active_q;

  always_comb begin
    cause         = '0;
    cause.crc     = crc_err && app_active_q;
    cause.ext_err = ext_err;
    cause.core    = core_req && !launch_req;
    cause.cfg_req = cfg_req;
    cause.wdog    = wd_expire;
  end

  assign fallback = |cause;
  assign launch   = launch_req && !fallback;

  always_comb begin
    app_active_d = app_active_q;
    pulse_d      = fallback || launch;
    addr_d       = '0;
    if (fallback) begin
      app_active_d = 1'b0;
    end else if (launch) begin
      app_active_d = 1'b1;
      addr_d       = {ctrl.start_hi, {ALIGN_W{1'b0}}};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      app_active_q <= 1'b0;
      pulse_q      <= 1'b0;
      addr_q       <= '0;
    end else begin
      app_active_q <= app_active_d;
      pulse_q      <= pulse_d;
      addr_q       <= addr_d;
    end
  end
endmodule

// File: rtl/recfg_status.sv
module recfg_status
  import recfg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  cause_t            cause,
  output logic [STAT_W-1:0] stat_q
);
  logic [STAT_W-1:0] stat_d;

  always_comb stat_d = stat_q | cause;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stat_q <= '0;
    else        stat_q <= stat_d;
  end
endmodule

// File: rtl/recfg_ctrl_unit.sv
module recfg_ctrl_unit
  import recfg_pkg::*;
#(
  parameter int PRESCALE = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_en,
  input  logic              reg_wr,
  input  logic              reg_sel,
  input  logic [CTRL_W-1:0] reg_wdata,
  output logic [CTRL_W-1:0] reg_rdata,
  input  logic              wdog_kick,
  input  logic              crc_err,
  input  logic              ext_err,
  input  logic              ext_cfg_req,
  input  logic              core_reconfig,
  output logic              recfg_pulse,
  output logic [ADDR_W-1:0] recfg_addr
);
  logic              rst_sync_n;
  ctrl_t             ctrl_q;
  cause_t            cause;
  logic              fallback, launch, wd_expire, wd_run, ctrl_wr;
  logic [STAT_W-1:0] stat_q;

  recfg_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n)
  );

  assign ctrl_wr = reg_wr && (reg_sel_e'(reg_sel) == SEL_CTRL);

  recfg_ctrl_regs u_regs (
    .clk(clk), .rst_n(rst_sync_n), .wr_en(ctrl_wr),
    .wdata(ctrl_t'(reg_wdata)), .fallback(fallback), .ctrl_q(ctrl_q)
  );

  assign wd_run = ctrl_q.app_image || ctrl_q.wd_en;

  recfg_wdog #(.TO_W(TO_W), .PRESCALE(PRESCALE)) u_wdog (
    .clk(clk), .rst_n(rst_sync_n), .run(wd_run), .tick_en(tick_en),
    .kick(wdog_kick), .clear(fallback || launch),
    .timeout(ctrl_q.wd_timeout), .expire(wd_expire)
  );

  recfg_sequencer u_seq (
    .clk(clk), .rst_n(rst_sync_n), .ctrl(ctrl_q),
    .core_req(core_reconfig), .crc_err(crc_err), .ext_err(ext_err),
    .cfg_req(ext_cfg_req), .wd_expire(wd_expire), .cause(cause),
    .fallback(fallback), .launch(launch),
    .pulse_q(recfg_pulse), .addr_q(recfg_addr)
  );

  recfg_status u_stat (
    .clk(clk), .rst_n(rst_sync_n), .cause(cause), .stat_q(stat_q)
  );

  always_comb begin
    if (reg_sel_e'(reg_sel) == SEL_STAT) reg_rdata = {{(CTRL_W-STAT_W){1'b0}}, stat_q};
    else                                 reg_rdata = ctrl_q;
  end
endmodule

// File: rtl/recfg_ctrl_unit_chk.sv
module recfg_ctrl_unit_chk
  import recfg_pkg::*;
(
  input logic              clk,
  input logic              rst_ln,
  input logic              reg_wr,
  input logic              ext_err,
  input logic              ext_cfg_req,
  input logic              fallback,
  input logic [CTRL_W-1:0] ctrl_v,
  input logic [STAT_W-1:0] stat_v,
  input logic              recfg_pulse,
  input logic [ADDR_W-1:0] recfg_addr
);
  AST_STATUS_STICKY: assert property (@(posedge clk) disable iff (!rst_ln)
    (stat_v & $past(stat_v)) == $past(stat_v)); // R11

  AST_LOCKED_WRITE: assert property (@(posedge clk) disable iff (!rst_ln)
    (reg_wr && ctrl_v[0] && !fallback) |=> $stable(ctrl_v)); // R3

  AST_EXT_ERR_FALLBACK: assert property (@(posedge clk) disable iff (!rst_ln)
    ext_err |=> (recfg_pulse && recfg_addr == '0 && stat_v[1])); // R5

  AST_CFG_REQ_FALLBACK: assert property (@(posedge clk) disable iff (!rst_ln)
    ext_cfg_req |=> (recfg_pulse && ctrl_v == '0 && stat_v[3])); // R6

  AST_NEW_CAUSE_CLEARS: assert property (@(posedge clk) disable iff (!rst_ln)
    (stat_v != $past(stat_v)) |-> (ctrl_v == '0 && recfg_pulse && recfg_addr == '0)); // R5

  AST_ADDR_ALIGNED: assert property (@(posedge clk) disable iff (!rst_ln)
    recfg_pulse |-> (recfg_addr[ALIGN_W-1:0] == '0)); // R4
endmodule

bind recfg_ctrl_unit recfg_ctrl_unit_chk u_chk (
  .clk(clk), .rst_ln(rst_sync_n), .reg_wr(reg_wr), .ext_err(ext_err),
  .ext_cfg_req(ext_cfg_req), .fallback(fallback), .ctrl_v(ctrl_q),
  .stat_v(stat_q), .recfg_pulse(recfg_pulse), .recfg_addr(recfg_addr)
);

// File: tb/recfg_ctrl_unit_test.sv
module recfg_ctrl_unit_test;
  localparam int CLK_PERIOD = 10;
  localparam int PRESCALE   = 2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick_en = 1'b0, reg_wr = 1'b0, reg_sel = 1'b0;
  logic [37:0] reg_wdata = '0;
  logic [37:0] reg_rdata;
  logic        wdog_kick = 1'b0, crc_err = 1'b0, ext_err = 1'b0;
  logic        ext_cfg_req = 1'b0, core_reconfig = 1'b0;
  logic        recfg_pulse;
  logic [31:0] recfg_addr;

  int n_checks = 0, n_fail = 0;
  bit done = 0;
  logic [31:0] exp_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  recfg_ctrl_unit #(.PRESCALE(PRESCALE)) uut (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .reg_wr(reg_wr),
    .reg_sel(reg_sel), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .wdog_kick(wdog_kick), .crc_err(crc_err), .ext_err(ext_err),
    .ext_cfg_req(ext_cfg_req), .core_reconfig(core_reconfig),
    .recfg_pulse(recfg_pulse), .recfg_addr(recfg_addr)
  );

  function automatic logic [37:0] mk(logic app, logic [23:0] st, logic wen, logic [11:0] to);
    return {to, wen, st, app};
  endfunction

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic wr_ctrl(logic [37:0] v);
    reg_wr = 1'b1; reg_sel = 1'b0; reg_wdata = v;
    step();
    reg_wr = 1'b0;
  endtask

  task automatic rd(logic sel, logic [37:0] exp, string req);
    reg_sel = sel;
    #1;
    chk(req, 64'(reg_rdata), 64'(exp));
  endtask

  task automatic por();
    rst_n = 1'b0;
    repeat (2) step();
    rst_n = 1'b1;
    repeat (3) step();
  endtask

  // scoreboard monitor: every reconfigure pulse must match the next expected address
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && recfg_pulse) begin
        n_checks++;
        if (exp_q.size() == 0) begin
          n_fail++;
          $display("FAIL R4/R5 unexpected pulse actual=%h expected=none", recfg_addr);
        end else begin
          logic [31:0] e;
          e = exp_q.pop_front();
          if (recfg_addr !== e) begin
            n_fail++;
            $display("FAIL R4/R5 pulse addr actual=%h expected=%h", recfg_addr, e);
          end
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog timeout actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    por();
    // R1 / R12
    chk("R1 pulse", 64'(recfg_pulse), 64'd0);
    rd(1'b0, '0, "R1 ctrl");
    rd(1'b1, '0, "R1 R12 status");

    // R2 readback in factory image
    wr_ctrl(mk(1'b0, 24'h5A3C96, 1'b0, 12'hA5F));
    rd(1'b0, mk(1'b0, 24'h5A3C96, 1'b0, 12'hA5F), "R2 readback");

    // R8 crc ignored in factory
    crc_err = 1'b1; step(); crc_err = 1'b0; step();
    chk("R8 no pulse in factory", 64'(recfg_pulse), 64'd0);
    rd(1'b1, '0, "R8 status untouched");

    // R3 lock
    wr_ctrl(mk(1'b1, 24'hABCDEF, 1'b0, 12'hFFF));
    wr_ctrl(mk(1'b0, 24'h111111, 1'b1, 12'h001));
    rd(1'b0, mk(1'b1, 24'hABCDEF, 1'b0, 12'hFFF), "R3 write ignored");

    // R4 launch
    exp_q.push_back(32'hABCDEF00);
    core_reconfig = 1'b1; step(); core_reconfig = 1'b0;
    chk("R4 pulse high", 64'(recfg_pulse), 64'd1);
    step();
    chk("R4 pulse one cycle", 64'(recfg_pulse), 64'd0);

    // R8 crc in application
    exp_q.push_back(32'h0);
    crc_err = 1'b1; step(); crc_err = 1'b0;
    rd(1'b1, 38'h01, "R8 crc status");
    rd(1'b0, '0, "R5 ctrl cleared");

    // R5 external error
    exp_q.push_back(32'h0);
    ext_err = 1'b1; step(); ext_err = 1'b0;
    rd(1'b1, 38'h03, "R5 ext_err status");

    // R7 internal request while application runs
    wr_ctrl(mk(1'b1, 24'h000010, 1'b0, 12'hFFF));
    exp_q.push_back(32'h00001000);
    core_reconfig = 1'b1; step(); core_reconfig = 1'b0;
    step();
    exp_q.push_back(32'h0);
    core_reconfig = 1'b1; step(); core_reconfig = 1'b0;
    rd(1'b1, 38'h07, "R7 core status");

    // R11 POR clears sticky status; simultaneous causes; R6
    por();
    rd(1'b1, '0, "R11 status cleared by POR");
    exp_q.push_back(32'h0);
    ext_err = 1'b1; ext_cfg_req = 1'b1; step(); ext_err = 1'b0; ext_cfg_req = 1'b0;
    rd(1'b1, 38'h0A, "R6 R11 simultaneous");

    // R9 / R10 watchdog in factory with enable, L = 3<<2 = 12
    tick_en = 1'b1;
    wr_ctrl(mk(1'b0, 24'h0, 1'b1, 12'd3));
    for (int i = 0; i < 9; i++) begin
      step();
      chk("R10 no early expiry", 64'(recfg_pulse), 64'd0);
    end
    wdog_kick = 1'b1; step(); wdog_kick = 1'b0;
    for (int i = 0; i < 12; i++) begin
      step();
      chk("R10 kick restarts count", 64'(recfg_pulse), 64'd0);
    end
    exp_q.push_back(32'h0);
    step();
    chk("R9 expiry due", 64'(recfg_pulse), 64'd1);
    rd(1'b1, 38'h1A, "R9 wdog status");
    tick_en = 1'b0;

    // R9 watchdog forced on by application flag, L = 1<<2 = 4
    wr_ctrl(mk(1'b1, 24'h000123, 1'b0, 12'd1));
    exp_q.push_back(32'h00012300);
    core_reconfig = 1'b1; step(); core_reconfig = 1'b0;
    tick_en = 1'b1;
    for (int i = 0; i < 4; i++) begin
      step();
      chk("R9 forced-on no early expiry", 64'(recfg_pulse), 64'd0);
    end
    exp_q.push_back(32'h0);
    step();
    chk("R9 forced-on expiry", 64'(recfg_pulse), 64'd1);
    rd(1'b0, '0, "R9 ctrl cleared");
    tick_en = 1'b0;
    step();

    chk("R5 all expected pulses seen", 64'(exp_q.size()), 64'd0);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end
endmodule